// File: doc/BRIEF.md
# Watchdog Control Register with NMI Redirection

This block is a 16-bit control register for a system-management watchdog. It is reached through a simple write/read port. It holds five control fields:

- **Lock.** Once set, it stays set until the next core-well reset. A neighbouring register uses the lock output to refuse changes to its own timer-enable bit.
- **Halt.** Freezes the watchdog count by removing the count-enable output.
- **Send request.** A message engine outside this block acknowledges the request with a completion pulse, and the bit then clears.
- **Redirect.** Turns incoming non-maskable interrupt (NMI) events into system-management interrupt (SMI) pulses.
- **Software NMI.** Raises an NMI once and then blocks further software NMIs until the handler clears it by writing 1.

The countdown timer, the message engine and the status register are outside the block. They connect through the count-enable, send-request/completion and redirect-event signals.

NMI sources are the external event input, gated by a mask input, and the software NMI trigger. The merged source goes to the NMI pulse output. When redirection is set, it goes to the SMI pulse output instead, gated by a global SMI enable input. All pulses are one clock wide and are registered.

Top module: `wdog_ctl_reg`

## Requirements
- R1: After reset the register reads 0000h. Bits 15:13 and 7:0 always read 0, and all pulse outputs are 0.
- R2: Bit 12 (lock) is set by a write with bit 12 = 1. A write with bit 12 = 0 leaves it unchanged, and only reset clears it. `lock_o` equals the bit.
- R3: Bit 11 (halt) is read/write. `cnt_en_o` is 1 exactly when bit 11 is 0.
- R4: Bit 10 (send) is set by a write with bit 10 = 1 while it is 0. It stays 1 until `send_done` is seen while it is 1, and then it clears on that edge. A write of 1 while it is already 1 is ignored, and `send_done` while it is 0 is ignored. `send_req_o` equals the bit.
- R5: Bit 9 (redirect) is read/write. While it is 1, an NMI source produces no NMI pulse. Instead it produces a `redir_evt_o` pulse, and an SMI pulse when the gate in R6 allows it.
- R6: No SMI pulse is produced while `gsmi_en` is 0.
- R7: While `nmi_mask` is 1, `nmi_evt` produces no NMI, SMI or redirect-event pulse.
- R8: Bit 8 (software NMI) behaves as follows:
  - A write with bit 8 = 1 while the bit is 0 sets it and is an NMI source.
  - A write with bit 8 = 1 while the bit is 1 clears it, and is not a source.
  - A write with bit 8 = 0 has no effect on it.
- R9: Every pulse appears on the first clock edge after the cycle holding its triggering write or event, and lasts exactly one cycle.
- R10: An external event and a software NMI in the same cycle produce exactly one pulse on the selected output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low core-well reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register value |
| send_done | input | 1 | Completion pulse from the message engine |
| nmi_evt | input | 1 | External NMI event |
| nmi_mask | input | 1 | 1 = external NMI events masked |
| gsmi_en | input | 1 | Global SMI enable |
| lock_o | output | 1 | Lock state for the timer-enable owner |
| cnt_en_o | output | 1 | Watchdog count enable |
| send_req_o | output | 1 | Pending send request |
| nmi_o | output | 1 | NMI pulse |
| smi_o | output | 1 | SMI pulse |
| redir_evt_o | output | 1 | Redirect status event pulse |

## Verification
Register fields and the outputs that mirror them (`lock_o`, `cnt_en_o`, `send_req_o`) change on the edge that captures the write or completion. The NMI, SMI and redirect-event pulses are due on that same first edge after their triggering cycle, and nowhere else. The bench drives each cycle's inputs just after a falling edge and compares every output two nanoseconds after the following rising edge. At that point the model has advanced exactly one step, so a pulse that is late, early or two cycles wide shows up as a mismatch.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
   localparam int unsigned REG_W    = 16;
   localparam int unsigned B_LOCK   = 12;
   localparam int unsigned B_HALT   = 11;
   localparam int unsigned B_SEND   = 10;
   localparam int unsigned B_REDIR  = 9;
   localparam int unsigned B_SWNMI  = 8;

   typedef struct packed {
      logic lock;
      logic halt;
      logic send;
      logic redir;
      logic swnmi;
   } wdc_fields_t;
endpackage

// File: rtl/wdc_field_bits.sv
module wdc_field_bits (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wd_lock,
   input  logic wd_halt,
   input  logic wd_redir,
   output logic lock_q,
   output logic halt_q,
   output logic redir_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q  <= 1'b0;
         halt_q  <= 1'b0;
         redir_q <= 1'b0;
      end else if (wr_en) begin
         lock_q  <= lock_q | wd_lock;
         halt_q  <= wd_halt;
         redir_q <= wd_redir;
      end
   end

   // R2: lock only leaves 1 through reset
   a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);
   // R3: halt follows write data
   a_r3_halt_written: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (halt_q == $past(wd_halt)));
endmodule

// File: rtl/wdc_send_hs.sv
module wdc_send_hs (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic done,
   output logic send_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         send_q <= 1'b0;
      else if (!send_q && set_req)
         send_q <= 1'b1;
      else if (send_q && done)
         send_q <= 1'b0;
   end

   // R4: request held until completion
   a_r4_send_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (send_q && !done) |=> send_q);
   // R4: completion clears, a repeated set does not keep it
   a_r4_send_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (send_q && done) |=> !send_q);
   // R4: completion while idle does not set
   a_r4_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!send_q && !set_req) |=> !send_q);
endmodule

// File: rtl/wdc_nmi_route.sv
module wdc_nmi_route #(
   parameter int unsigned EVT_SYNC = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_hit,
   input  logic nmi_evt,
   input  logic nmi_mask,
   input  logic redir,
   input  logic gsmi_en,
   output logic sw_q,
   output logic nmi_o,
   output logic smi_o,
   output logic redir_evt_o
);
   logic evt_s;

   generate
      if (EVT_SYNC == 0) begin : g_nosync
         assign evt_s = nmi_evt;
      end else begin : g_sync
         logic [EVT_SYNC-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[EVT_SYNC-2:0], nmi_evt};
         end
         assign evt_s = sh[EVT_SYNC-1];
      end
      if (EVT_SYNC == 1) begin : g_bad_sync
         $error("EVT_SYNC must be 0 or at least 2");
      end
   endgenerate

   logic sw_trig, src;
   assign sw_trig = sw_hit & ~sw_q;
   assign src     = (evt_s & ~nmi_mask) | sw_trig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_q        <= 1'b0;
         nmi_o       <= 1'b0;
         smi_o       <= 1'b0;
         redir_evt_o <= 1'b0;
      end else begin
         if (sw_hit) sw_q <= ~sw_q;
         nmi_o       <= src & ~redir;
         smi_o       <= src & redir & gsmi_en;
         redir_evt_o <= src & redir;
      end
   end

   // R10: never both outputs in one cycle
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !(nmi_o && smi_o));
   // R6: SMI needs the global enable
   a_r6_smi_gated: assert property (@(posedge clk) disable iff (!rst_n)
      smi_o |-> $past(gsmi_en));
   // R5: no NMI while redirecting
   a_r5_no_nmi_redir: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_o |-> !$past(redir));
   // R8: software NMI bit holds unless written with 1
   a_r8_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_hit |=> $stable(sw_q));
   // R9: a set software NMI bit cannot trigger again
   a_r9_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_q && !evt_s) |=> !nmi_o && !smi_o);
endmodule

// File: rtl/wdog_ctl_reg.sv
module wdog_ctl_reg #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned EVT_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              send_done,
   input  logic              nmi_evt,
   input  logic              nmi_mask,
   input  logic              gsmi_en,
   output logic              lock_o,
   output logic              cnt_en_o,
   output logic              send_req_o,
   output logic              nmi_o,
   output logic              smi_o,
   output logic              redir_evt_o
);
   import wdc_pkg::*;

   if (DATA_W < B_LOCK + 1) begin : g_bad_width
      $error("DATA_W too small for the lock field");
   end

   wdc_fields_t f;

   wdc_field_bits u_bits (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wd_lock  (wr_data[B_LOCK]),
      .wd_halt  (wr_data[B_HALT]),
      .wd_redir (wr_data[B_REDIR]),
      .lock_q   (f.lock),
      .halt_q   (f.halt),
      .redir_q  (f.redir)
   );

   wdc_send_hs u_send (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (wr_en & wr_data[B_SEND]),
      .done    (send_done),
      .send_q  (f.send)
   );

   wdc_nmi_route #(.EVT_SYNC(EVT_SYNC)) u_route (
      .clk         (clk),
      .rst_n       (rst_n),
      .sw_hit      (wr_en & wr_data[B_SWNMI]),
      .nmi_evt     (nmi_evt),
      .nmi_mask    (nmi_mask),
      .redir       (f.redir),
      .gsmi_en     (gsmi_en),
      .sw_q        (f.swnmi),
      .nmi_o       (nmi_o),
      .smi_o       (smi_o),
      .redir_evt_o (redir_evt_o)
   );

   always_comb begin
      rd_data          = '0;
      rd_data[B_LOCK]  = f.lock;
      rd_data[B_HALT]  = f.halt;
      rd_data[B_SEND]  = f.send;
      rd_data[B_REDIR] = f.redir;
      rd_data[B_SWNMI] = f.swnmi;
   end

   assign lock_o     = f.lock;
   assign cnt_en_o   = ~f.halt;
   assign send_req_o = f.send;

   // R1: reserved bits stay zero
   a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[7:0] == 8'h00) && (rd_data[DATA_W-1:B_LOCK+1] == '0));
   // R9: redirect event pulse is one cycle wide unless retriggered
   a_r9_evt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (redir_evt_o && !nmi_evt && !(wr_en && wr_data[B_SWNMI])) |=> !redir_evt_o);
endmodule

// File: tb/tb_wdog_ctl_reg.sv
`timescale 1ns/1ps
module tb_wdog_ctl_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        send_done = 1'b0, nmi_evt = 1'b0, nmi_mask = 1'b0, gsmi_en = 1'b0;
   logic        lock_o, cnt_en_o, send_req_o, nmi_o, smi_o, redir_evt_o;

   int n_run = 0, n_fail = 0;
   logic m_lock, m_halt, m_send, m_redir, m_sw, e_nmi, e_smi, e_rev;

   always #5 clk = ~clk;

   wdog_ctl_reg dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .send_done(send_done), .nmi_evt(nmi_evt), .nmi_mask(nmi_mask), .gsmi_en(gsmi_en),
      .lock_o(lock_o), .cnt_en_o(cnt_en_o), .send_req_o(send_req_o),
      .nmi_o(nmi_o), .smi_o(smi_o), .redir_evt_o(redir_evt_o));

   function automatic logic [15:0] exp_rd();
      return {3'b000, m_lock, m_halt, m_send, m_redir, m_sw, 8'h00};
   endfunction

   task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      cmp("R1 reserved", rd_data & 16'hE0FF, 16'h0000);
      cmp("R2 lock", {15'd0, lock_o}, {15'd0, m_lock});
      cmp("R3 cnt_en", {15'd0, cnt_en_o}, {15'd0, ~m_halt});
      cmp("R4 send_req", {15'd0, send_req_o}, {15'd0, m_send});
      cmp("R8 register", rd_data, exp_rd());
      cmp("R5 R9 nmi", {15'd0, nmi_o}, {15'd0, e_nmi});
      cmp("R6 R9 smi", {15'd0, smi_o}, {15'd0, e_smi});
      cmp("R7 R10 redir_evt", {15'd0, redir_evt_o}, {15'd0, e_rev});
   endtask

   task automatic model_reset();
      {m_lock, m_halt, m_send, m_redir, m_sw, e_nmi, e_smi, e_rev} = '0;
   endtask

   // one cycle: inputs applied after a falling edge, checked 2 ns after the rising edge
   task automatic step(input logic w, input logic [15:0] d, input logic dn,
                       input logic ev, input logic mk, input logic gs);
      logic trig, src;
      wr_en = w; wr_data = d; send_done = dn; nmi_evt = ev; nmi_mask = mk; gsmi_en = gs;
      trig  = w & d[8] & ~m_sw;
      src   = (ev & ~mk) | trig;
      e_nmi = src & ~m_redir;
      e_smi = src & m_redir & gs;
      e_rev = src & m_redir;
      if (!m_send && w && d[10]) m_send = 1'b1;
      else if (m_send && dn)     m_send = 1'b0;
      if (w) begin
         m_lock  = m_lock | d[12];
         m_halt  = d[11];
         m_redir = d[9];
         if (d[8]) m_sw = ~m_sw;
      end
      @(posedge clk); #2;
      check_all();
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      model_reset();
      repeat (3) @(negedge clk);
      check_all();                                    // R1 reset state
      rst_n = 1'b1;
      @(negedge clk);
      // R2: set lock, then write 0 has no effect
      step(1, 16'h1000, 0, 0, 0, 1);
      step(1, 16'h0000, 0, 0, 0, 1);
      // R3: halt on then off
      step(1, 16'h1800, 0, 0, 0, 1);
      step(1, 16'h1000, 0, 0, 0, 1);
      // R4: set, repeat set ignored, done clears, done while idle ignored
      step(1, 16'h0400, 0, 0, 0, 1);
      step(1, 16'h0400, 0, 0, 0, 1);
      step(0, 16'h0000, 1, 0, 0, 1);
      step(0, 16'h0000, 1, 0, 0, 1);
      // R8: software NMI, second write clears without pulse
      step(1, 16'h0100, 0, 0, 0, 1);
      step(1, 16'h0000, 0, 0, 0, 1);
      step(1, 16'h0100, 0, 0, 0, 1);
      // R10: event plus software NMI together
      step(1, 16'h0100, 0, 1, 0, 1);
      step(1, 16'h0100, 0, 0, 0, 1);
      // R5/R6: redirect with and without global enable
      step(1, 16'h0200, 0, 0, 0, 1);
      step(0, 16'h0000, 0, 1, 0, 1);
      step(0, 16'h0000, 0, 1, 0, 0);
      // R7: masked event
      step(0, 16'h0000, 0, 1, 1, 1);
      // R2: reset clears lock
      rst_n = 1'b0; model_reset(); @(negedge clk); check_all();
      rst_n = 1'b1; @(negedge clk);
      for (int i = 0; i < 4000; i++) begin
         logic [15:0] d;
         d = 16'($urandom);
         step(($urandom % 3) == 0, d, ($urandom % 4) == 0, ($urandom % 3) == 0,
              ($urandom % 4) == 0, ($urandom % 4) != 0);
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule